// File: doc/BRIEF.md
# Mode-Aware Branch Target Generator

This block produces the address of the next instruction for a core that can run with either a 64-bit or a 32-bit effective address. Each strobed request carries the current instruction address, a sign-extended displacement, an absolute-addressing select, a value read from a target register, a two-bit branch kind and a taken bit. Condition and counter evaluation happen upstream and arrive as that taken bit. Decode also happens upstream.

The block forms the branch destination in one of two ways. A displacement branch uses either the displacement alone or the instruction address plus the displacement. A register branch uses the register value with its low two bits cleared. When the branch does not redirect, the next address is the sequential one, four bytes on. Every result is then limited to the low 32 bits when the wide-mode input is low. The result is registered and appears one cycle after the request.

Top module: `branch_target_gen`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is released, `out_valid` is 0 and `next_addr` is 0.
- R2: `out_valid` is 1 exactly in the cycle after a cycle in which `in_valid` was 1. In cycles without a request, `next_addr` keeps its previous value.
- R3: For a displacement branch (kind 0 = unconditional, or kind 1 = conditional and taken) with `abs_sel` = 1, the destination is `disp` itself.
- R4: For a displacement branch with `abs_sel` = 0, the destination is `pc + disp`, wrapped modulo 2^64.
- R5: For a taken register branch (kind 2), the destination is `reg_tgt` with bits [1:0] cleared.
- R6: A conditional (kind 1) or register (kind 2) request with `taken` = 0 yields `pc + 4`. For kind 0 the `taken` input is ignored and the branch always redirects.
- R7: Kind 3 marks a non-branch request and always yields `pc + 4`, whatever the values of `taken`, `abs_sel`, `disp` and `reg_tgt`.
- R8: When `wide_mode` = 0, bits [63:32] of `next_addr` are zero for every kind. This includes the fall-through result and results whose addition carried past bit 31.
- R9: When `wide_mode` = 1, the full 64-bit result is delivered unchanged.
- R10: For register branches, alignment happens before truncation. In narrow mode the result is `reg_tgt[31:0]` with bits [1:0] cleared and the upper half zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe |
| pc | input | 64 | Address of the current instruction |
| disp | input | 64 | Sign-extended displacement |
| abs_sel | input | 1 | 1: displacement is the absolute target |
| reg_tgt | input | 64 | Target value read from a register |
| kind | input | 2 | 0 uncond disp, 1 cond disp, 2 register, 3 sequential |
| taken | input | 1 | Branch condition result from upstream |
| wide_mode | input | 1 | 1: 64-bit addressing, 0: 32-bit addressing |
| out_valid | output | 1 | Next address valid |
| next_addr | output | 64 | Computed next instruction address |

## Verification
The bound checker tests the following properties on every cycle:
- the valid strobe follows the request by one cycle, and the output holds when there is no request;
- the upper half of the result is zero whenever narrow mode was requested;
- a taken register branch gives a word-aligned result;
- a not-taken conditional gives the sequential address in wide mode;
- an absolute unconditional branch gives the displacement in wide mode.

Only the bench scenarios show the rest: the wrap of the relative addition, carries across bit 31 that truncation must remove, alignment happening before truncation, kind 0 ignoring `taken`, kind 3 ignoring every target input, and back-to-back requests in which the mode changes between them.

// File: rtl/bta_pkg.sv
package bta_pkg;
    typedef enum logic [1:0] {
        KIND_UNCOND = 2'd0,
        KIND_COND   = 2'd1,
        KIND_REG    = 2'd2,
        KIND_SEQ    = 2'd3
    } br_kind_e;
endpackage

// File: rtl/bta_rel_target.sv
module bta_rel_target #(
    parameter int ADDR_W = 64
) (
    input  logic [ADDR_W-1:0] pc,
    input  logic [ADDR_W-1:0] disp,
    input  logic              abs_sel,
    output logic [ADDR_W-1:0] tgt
);
    logic [ADDR_W-1:0] sum;

    always_comb begin
        sum = pc + disp;
        tgt = abs_sel ? disp : sum;
    end
endmodule

// File: rtl/bta_reg_align.sv
module bta_reg_align #(
    parameter int ADDR_W     = 64,
    parameter int ALIGN_BITS = 2
) (
    input  logic [ADDR_W-1:0] raw,
    output logic [ADDR_W-1:0] aligned
);
    localparam logic [ADDR_W-1:0] LOW_MASK = ADDR_W'((64'd1 << ALIGN_BITS) - 64'd1);

    always_comb begin
        aligned = raw & ~LOW_MASK;
    end
endmodule

// File: rtl/bta_mode_clip.sv
module bta_mode_clip #(
    parameter int ADDR_W   = 64,
    parameter int NARROW_W = 32
) (
    input  logic [ADDR_W-1:0] raw,
    input  logic              wide_mode,
    output logic [ADDR_W-1:0] clipped
);
    logic [ADDR_W-1:0] keep_mask;

    generate
        if (NARROW_W < ADDR_W) begin : g_clip
            localparam logic [ADDR_W-1:0] NARROW_MASK =
                {{(ADDR_W-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};
            always_comb begin
                keep_mask = wide_mode ? '1 : NARROW_MASK;
            end
        end else begin : g_pass
            always_comb begin
                keep_mask = '1;
            end
        end
    endgenerate

    always_comb begin
        clipped = raw & keep_mask;
    end
endmodule

// File: rtl/branch_target_gen.sv
module branch_target_gen #(
    parameter int ADDR_W      = 64,
    parameter int NARROW_W    = 32,
    parameter int ALIGN_BITS  = 2,
    parameter int INSTR_BYTES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [ADDR_W-1:0] pc,
    input  logic [ADDR_W-1:0] disp,
    input  logic              abs_sel,
    input  logic [ADDR_W-1:0] reg_tgt,
    input  logic [1:0]        kind,
    input  logic              taken,
    input  logic              wide_mode,
    output logic              out_valid,
    output logic [ADDR_W-1:0] next_addr
);
    import bta_pkg::*;

    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(INSTR_BYTES);

    typedef struct packed {
        logic              vld;
        logic [ADDR_W-1:0] addr;
    } state_t;

    state_t            st_d, st_q;
    logic [ADDR_W-1:0] disp_tgt;
    logic [ADDR_W-1:0] reg_aligned;
    logic [ADDR_W-1:0] seq_addr;
    logic [ADDR_W-1:0] pick;
    logic [ADDR_W-1:0] pick_clipped;
    br_kind_e          kind_e;

    bta_rel_target #(.ADDR_W(ADDR_W)) u_rel (
        .pc      (pc),
        .disp    (disp),
        .abs_sel (abs_sel),
        .tgt     (disp_tgt)
    );

    bta_reg_align #(.ADDR_W(ADDR_W), .ALIGN_BITS(ALIGN_BITS)) u_align (
        .raw     (reg_tgt),
        .aligned (reg_aligned)
    );

    bta_mode_clip #(.ADDR_W(ADDR_W), .NARROW_W(NARROW_W)) u_clip (
        .raw       (pick),
        .wide_mode (wide_mode),
        .clipped   (pick_clipped)
    );

    always_comb begin
        kind_e   = br_kind_e'(kind);
        seq_addr = pc + STEP;
        unique case (kind_e)
            KIND_UNCOND: pick = disp_tgt;
            KIND_COND:   pick = taken ? disp_tgt : seq_addr;
            KIND_REG:    pick = taken ? reg_aligned : seq_addr;
            default:     pick = seq_addr;
        endcase

        st_d     = st_q;
        st_d.vld = in_valid;
        if (in_valid) begin
            st_d.addr = pick_clipped;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.vld;
    assign next_addr = st_q.addr;
endmodule

// File: rtl/bta_checker.sv
module bta_checker #(
    parameter int ADDR_W   = 64,
    parameter int NARROW_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [ADDR_W-1:0] pc,
    input logic [ADDR_W-1:0] disp,
    input logic              abs_sel,
    input logic [1:0]        kind,
    input logic              taken,
    input logic              wide_mode,
    input logic              out_valid,
    input logic [ADDR_W-1:0] next_addr
);
    localparam logic [ADDR_W-1:0] FOUR = ADDR_W'(4);

    // R2: strobe follows request by one cycle
    a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_valid && $past(rst_n)) |=> $stable(next_addr));

    // R8: narrow mode clears the upper half
    a_r8_narrow_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !wide_mode) |=> (next_addr[ADDR_W-1:NARROW_W] == '0));

    // R5: taken register branch is word aligned
    a_r5_reg_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && kind == 2'd2 && taken) |=> (next_addr[1:0] == 2'b00));

    // R6: not-taken conditional falls through
    a_r6_fallthrough: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && kind == 2'd1 && !taken && wide_mode) |=> (next_addr == $past(pc) + FOUR));

    // R3: absolute unconditional branch
    a_r3_absolute: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && kind == 2'd0 && abs_sel && wide_mode) |=> (next_addr == $past(disp)));
endmodule

bind branch_target_gen bta_checker #(.ADDR_W(ADDR_W), .NARROW_W(NARROW_W)) u_bta_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .pc        (pc),
    .disp      (disp),
    .abs_sel   (abs_sel),
    .kind      (kind),
    .taken     (taken),
    .wide_mode (wide_mode),
    .out_valid (out_valid),
    .next_addr (next_addr)
);

// File: tb/test_branch_target_gen.sv
module test_branch_target_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [63:0] pc = '0;
    logic [63:0] disp = '0;
    logic        abs_sel = 1'b0;
    logic [63:0] reg_tgt = '0;
    logic [1:0]  kind = '0;
    logic        taken = 1'b0;
    logic        wide_mode = 1'b1;
    logic        out_valid;
    logic [63:0] next_addr;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    logic [63:0] exp_q[$];
    string       tag_q[$];

    always #10ns clk = ~clk;

    branch_target_gen i_branch_target_gen (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .pc        (pc),
        .disp      (disp),
        .abs_sel   (abs_sel),
        .reg_tgt   (reg_tgt),
        .kind      (kind),
        .taken     (taken),
        .wide_mode (wide_mode),
        .out_valid (out_valid),
        .next_addr (next_addr)
    );

    function automatic logic [63:0] model(input logic [63:0] p, input logic [63:0] d,
                                          input logic a, input logic [63:0] r,
                                          input logic [1:0] k, input logic t, input logic w);
        logic [63:0] tg;
        logic [63:0] res;
        tg = a ? d : p + d;
        case (k)
            2'd0:    res = tg;
            2'd1:    res = t ? tg : p + 64'd4;
            2'd2:    res = t ? (r & ~64'd3) : p + 64'd4;
            default: res = p + 64'd4;
        endcase
        if (!w) res[63:32] = '0;
        return res;
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic send(input string req, input logic [63:0] p, input logic [63:0] d,
                        input logic a, input logic [63:0] r, input logic [1:0] k,
                        input logic t, input logic w);
        @(negedge clk);
        in_valid = 1'b1; pc = p; disp = d; abs_sel = a; reg_tgt = r;
        kind = k; taken = t; wide_mode = w;
        exp_q.push_back(model(p, d, a, r, k, t, w));
        tag_q.push_back(req);
    endtask

    task automatic idle();
        @(negedge clk);
        in_valid = 1'b0;
        pc = 64'hDEAD_BEEF_0BAD_F00D; disp = 64'h1234; reg_tgt = 64'hFFFF_FFFF_FFFF_FFFF;
    endtask

    // monitor: pops expected items as results appear
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (exp_q.size() == 0) begin
                checks++; errors++;
                $display("FAIL R2 actual=out_valid expected=no result");
            end else begin
                check(tag_q.pop_front(), next_addr, exp_q.pop_front());
            end
        end
    end

    initial begin
        #(200000 * 20ns);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog actual=running expected=done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [63:0] held;
        repeat (3) @(negedge clk);
        check("R1", {63'd0, out_valid}, 64'd0);
        check("R1", next_addr, 64'd0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", {63'd0, out_valid}, 64'd0);
        check("R1", next_addr, 64'd0);

        // R3 absolute, wide
        send("R3", 64'h0000_1000_0000_2000, 64'h0123_4567_89AB_CDE0, 1'b1, '0, 2'd0, 1'b1, 1'b1);
        // R4 relative, negative disp
        send("R4", 64'h0000_0000_0001_0000, 64'hFFFF_FFFF_FFFF_FF00, 1'b0, '0, 2'd0, 1'b1, 1'b1);
        // R4 wrap modulo 2^64
        send("R4", 64'hFFFF_FFFF_FFFF_FFF0, 64'h0000_0000_0000_0020, 1'b0, '0, 2'd1, 1'b1, 1'b1);
        // R5 register taken, wide
        send("R5", 64'h100, '0, 1'b0, 64'h8765_4321_0FED_CBA7, 2'd2, 1'b1, 1'b1);
        // R6 cond not taken, reg not taken, uncond ignores taken
        send("R6", 64'h0000_0002_0000_0010, 64'h4000, 1'b0, '0, 2'd1, 1'b0, 1'b1);
        send("R6", 64'h0000_0003_0000_0020, '0, 1'b0, 64'h5555, 2'd2, 1'b0, 1'b1);
        send("R6", 64'h0000_0000_0000_0100, 64'h40, 1'b0, '0, 2'd0, 1'b0, 1'b1);
        // R7 sequential kind ignores target inputs
        send("R7", 64'h0000_0004_0000_0040, 64'h7777, 1'b1, 64'h9999, 2'd3, 1'b1, 1'b1);
        // R8 narrow: carry across bit 31, fall-through, absolute
        send("R8", 64'h0000_0000_FFFF_FFF0, 64'h0000_0000_0000_0040, 1'b0, '0, 2'd0, 1'b1, 1'b0);
        send("R8", 64'h1234_5678_FFFF_FFFC, '0, 1'b0, '0, 2'd1, 1'b0, 1'b0);
        send("R8", '0, 64'hFFFF_FFFF_8000_0000, 1'b1, '0, 2'd1, 1'b1, 1'b0);
        // R10 register in narrow: align then truncate
        send("R10", 64'h200, '0, 1'b0, 64'hABCD_EF01_2345_678B, 2'd2, 1'b1, 1'b0);
        // R9 wide pass-through of a high address
        send("R9", 64'hF000_0000_0000_0000, 64'h0000_0000_8000_0004, 1'b0, '0, 2'd0, 1'b1, 1'b1);
        idle();
        @(negedge clk);
        // R2 hold with no request
        held = next_addr;
        repeat (3) @(negedge clk);
        check("R2", {63'd0, out_valid}, 64'd0);
        check("R2", next_addr, held);
        // R2 mode change between back-to-back requests
        send("R2", 64'hAAAA_0000_BBBB_0000, 64'h10, 1'b0, '0, 2'd0, 1'b1, 1'b0);
        send("R2", 64'hAAAA_0000_BBBB_0000, 64'h10, 1'b0, '0, 2'd0, 1'b1, 1'b1);
        idle();
        repeat (3) @(negedge clk);
        check("R2", 64'(exp_q.size()), 64'd0);
        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule